// File: doc/BRIEF.md
# Reset Control Port Register

This block is a one-byte register on an I/O bus. Software writes it for two reasons: to choose the kind of system reset that should follow, and to start that reset. The block answers at one port address, which is set by a parameter. All accesses are one byte wide. A write that has the trigger bit set produces a one-cycle request pulse for a downstream reset sequencer. That write leaves the stored byte untouched.

Any other write at the port keeps only the reset-type bit. Every other bit of the written byte is discarded. The stored type bit is also presented on a dedicated output, so the sequencer can sample it in the same cycle the request pulse appears.

A read at the port returns the stored byte in the same cycle and drives an output-enable. Accesses to any other address are ignored. During such reads the block neither drives the enable nor puts any value on the data lines.

Top module: `reset_ctl_port`

## Requirements
- R1: After reset the stored byte is 0x00, `rst_req` is low and `rst_type` is low.
- R2: A write at the port with data bit 2 set makes `rst_req` high in the cycle after the write, for exactly one cycle.
- R3: A write at the port with data bit 2 set leaves the stored byte and `rst_type` unchanged, whatever the other data bits are.
- R4: A write at the port with data bit 2 clear stores data bit 1 in stored bit 1 and forces every other stored bit to zero.
- R5: A read at the port drives `io_rdata_oe` high and `io_rdata` equal to the stored byte in the same cycle.
- R6: A write at any other address changes neither the stored byte nor `rst_type`, and raises no `rst_req`.
- R7: When no read at the port is in progress, `io_rdata_oe` is low and `io_rdata` is 0x00.
- R8: `rst_type` always equals stored bit 1, and it updates in the cycle after a storing write.
- R9: In any cycle that does not follow a trigger write at the port, `rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Byte write strobe |
| io_rd | input | 1 | Byte read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; zero unless a read at the port is in progress |
| io_rdata_oe | output | 1 | High while the block drives read data |
| rst_req | output | 1 | One-cycle system reset request |
| rst_type | output | 1 | Stored reset-type bit |

## Verification
The assertions assume three things about the inputs. The read and write strobes are never high in the same cycle. Address and data stay stable around each rising edge. No write at the port happens while reset is held.

The bench respects these assumptions. It changes inputs only on falling clock edges and issues one strobe at a time. Each strobe lasts one cycle and is separated from the next by at least one idle cycle.

It sweeps all 256 data values through writes at the port, following each write with a read. It also walks a single flipped bit across every address position, sending both trigger and non-trigger data to those mismatched addresses.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
    localparam int RCP_DW = 8;

    typedef struct packed {
        logic [RCP_DW-1:0] store;
        logic              req;
    } rcp_state_t;
endpackage

// File: rtl/rcp_addr_match.sv
module rcp_addr_match #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F9
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic sel;

    always_comb begin
        sel    = (io_addr == PORT_ADDR);
        wr_hit = sel & io_wr;
        rd_hit = sel & io_rd;
    end
endmodule

// File: rtl/rcp_ctrl_regs.sv
module rcp_ctrl_regs
    import rcp_pkg::*;
#(
    parameter int TRIG_BIT = 2,
    parameter int TYPE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [RCP_DW-1:0] wdata,
    output logic [RCP_DW-1:0] store,
    output logic              req
);
    localparam logic [RCP_DW-1:0] TRIG_MASK = RCP_DW'(1) << TRIG_BIT;
    localparam logic [RCP_DW-1:0] KEEP_MASK = RCP_DW'(1) << TYPE_BIT;

    rcp_state_t st_d, st_q;
    logic       trig;

    always_comb begin
        trig     = |(wdata & TRIG_MASK);
        st_d     = st_q;
        st_d.req = wr_hit & trig;
        if (wr_hit && !trig) begin
            st_d.store = wdata & KEEP_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign store = st_q.store;
    assign req   = st_q.req;
endmodule

// File: rtl/rcp_read_path.sv
module rcp_read_path
    import rcp_pkg::*;
(
    input  logic              rd_hit,
    input  logic [RCP_DW-1:0] store,
    output logic [RCP_DW-1:0] rdata,
    output logic              rdata_oe
);
    for (genvar i = 0; i < RCP_DW; i++) begin : g_gate
        assign rdata[i] = rd_hit & store[i];
    end
    assign rdata_oe = rd_hit;
endmodule

// File: rtl/reset_ctl_port.sv
module reset_ctl_port
    import rcp_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F9,
    parameter int                TRIG_BIT  = 2,
    parameter int                TYPE_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_rdata_oe,
    output logic              rst_req,
    output logic              rst_type
);
    logic              wr_hit, rd_hit;
    logic [RCP_DW-1:0] store;

    rcp_addr_match #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_match (
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .wr_hit  (wr_hit),
        .rd_hit  (rd_hit)
    );

    rcp_ctrl_regs #(.TRIG_BIT(TRIG_BIT), .TYPE_BIT(TYPE_BIT)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (io_wdata),
        .store  (store),
        .req    (rst_req)
    );

    rcp_read_path u_rd (
        .rd_hit   (rd_hit),
        .store    (store),
        .rdata    (io_rdata),
        .rdata_oe (io_rdata_oe)
    );

    assign rst_type = store[TYPE_BIT];
endmodule

// File: rtl/rcp_checker.sv
module rcp_checker #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h00F9,
    parameter int                TRIG_BIT  = 2,
    parameter int                TYPE_BIT  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              io_rdata_oe,
    input logic              rst_req,
    input logic              rst_type
);
    logic at_port;
    assign at_port = (io_addr == PORT_ADDR);

    // R2
    a_r2_req_follows_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_port && io_wdata[TRIG_BIT]) |=> rst_req);
    // R9
    a_r9_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && at_port && io_wdata[TRIG_BIT]) |=> !rst_req);
    // R3
    a_r3_trigger_keeps_type: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_port && io_wdata[TRIG_BIT]) |=> $stable(rst_type));
    // R4
    a_r4_store_type: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && at_port && !io_wdata[TRIG_BIT]) |=> rst_type == $past(io_wdata[TYPE_BIT]));
    // R6
    a_r6_foreign_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && at_port) |=> $stable(rst_type));
    // R5
    a_r5_read_value: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && at_port) |-> (io_rdata_oe && io_rdata == (8'(rst_type) << TYPE_BIT)));
    // R7
    a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && at_port) |-> (!io_rdata_oe && io_rdata == 8'h00));
endmodule

bind reset_ctl_port rcp_checker #(
    .ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR), .TRIG_BIT(TRIG_BIT), .TYPE_BIT(TYPE_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
    .rst_req(rst_req), .rst_type(rst_type)
);

// File: tb/reset_ctl_port_test.sv
`timescale 1ns/1ps
module reset_ctl_port_test;
    localparam int          AW   = 16;
    localparam logic [15:0] PORT = 16'h00F9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rdata_oe;
    logic        rst_req;
    logic        rst_type;

    int errors = 0;
    int checks = 0;
    logic [7:0] model = 8'h00;

    always #2.5 clk = ~clk;

    reset_ctl_port #(.ADDR_W(AW), .PORT_ADDR(PORT)) uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe),
        .rst_req(rst_req), .rst_type(rst_type)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [15:0] a, input logic [7:0] exp, input logic exp_oe,
                            input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        chk(tag, io_rdata, exp);
        chk(tag, 8'(io_rdata_oe), 8'(exp_oe));
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rst_req", 8'(rst_req), 8'h00);
        chk("R1 rst_type", 8'(rst_type), 8'h00);
        rst_n = 1'b1;
        rd_check(PORT, 8'h00, 1'b1, "R1 read after reset");

        // R2 R3 R4 R5 R8: every data value at the port
        for (int v = 0; v < 256; v++) begin
            logic [7:0] d;
            d = 8'(v);
            wr_cycle(PORT, d);
            chk("R2 pulse", 8'(rst_req), 8'(d[2]));
            if (!d[2]) model = d & 8'h02;
            chk(d[2] ? "R3 type held" : "R8 type", 8'(rst_type), 8'(model[1]));
            @(negedge clk);
            chk("R9 pulse ends", 8'(rst_req), 8'h00);
            rd_check(PORT, model, 1'b1, d[2] ? "R3 read" : "R4 read");
        end

        // R6 R7: one flipped address bit at a time
        for (int k = 0; k < AW; k++) begin
            logic [15:0] a;
            a = PORT ^ (16'h1 << k);
            wr_cycle(a, (k % 2 == 0) ? 8'h06 : (model ^ 8'h02));
            chk("R6 no req", 8'(rst_req), 8'h00);
            chk("R6 type", 8'(rst_type), 8'(model[1]));
            rd_check(a, 8'h00, 1'b0, "R7 foreign read");
            rd_check(PORT, model, 1'b1, "R6 unchanged");
        end

        // R7 idle bus, R9 idle req
        @(negedge clk);
        io_addr = PORT;
        #1;
        chk("R7 idle data", io_rdata, 8'h00);
        chk("R7 idle oe", 8'(io_rdata_oe), 8'h00);
        chk("R9 idle", 8'(rst_req), 8'h00);

        // R1 again: reset clears a stored type bit
        wr_cycle(PORT, 8'h02);
        chk("R4 set type", 8'(rst_type), 8'h01);
        rst_n = 1'b0;
        #1;
        chk("R1 async clear", 8'(rst_type), 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        model = 8'h00;
        rd_check(PORT, 8'h00, 1'b1, "R1 read after second reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule